// File: doc/BRIEF.md
# SCSI Pseudo-DMA Byte Lane Sequencer

This block sits between a 32-bit processor bus and the 8-bit data and register port of a SCSI controller. A single processor access enters as a one-cycle request. The block turns it into one or more byte transfers on the controller side. It holds the access until the last byte has moved, then ends it with a one-cycle acknowledge. If the controller never becomes ready, it ends the access with a one-cycle bus error instead.

There are two address windows. In the register window, the controller register number is taken from bits [6:3] of the halfword offset, and data travels on bits [15:8] of the bus. Two offsets in that window are not ordinary register accesses. A read at 0x130 and a write at 0x100 each move one data byte under the controller's data-request flow control.

In the pseudo-DMA window, the byte-enable mask selects a burst of 1, 2 or 4 bytes. Reads always target controller register 6 and writes always target register 0. Bytes move most significant lane first. Each data byte waits for the data-request input, under a per-byte timeout whose length is set by an input.

Top module: `scsi_pdma_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `cpu_ack`, `cpu_berr` and `ctl_sel` are low and `cpu_rdata` is zero.
- R2: A register-window read at any offset other than 0x130 makes exactly one controller read of register `cpu_hoff[6:3]` with `ctl_pdma` low and without waiting for `ctl_drq`. The byte is returned in `cpu_rdata[15:8]`, with every other bit zero.
- R3: A register-window write at any offset other than 0x100 makes exactly one controller write of register `cpu_hoff[6:3]` carrying `cpu_wdata[15:8]`, with `ctl_pdma` low.
- R4: A register-window read at offset 0x130 is a single-byte data read of register 6, and a write at 0x100 is a single-byte data write of register 0. Both have `ctl_pdma` high and both wait for `ctl_drq`. A read at 0x100 and a write at 0x130 stay ordinary accesses.
- R5: A pseudo-DMA window read reads register 6. With mask 4'b1000 it reads one byte into [31:24]. With mask 4'b1100 it reads two bytes into [31:24] then [23:16]. With mask 4'b1111 it reads four bytes into [31:24], [23:16], [15:8], [7:0] in that order. Unfilled bits are zero.
- R6: A pseudo-DMA window write with the same three masks writes 1, 2 or 4 bytes to register 0, taken from `cpu_wdata` starting at [31:24] and moving down one lane per byte.
- R7: A pseudo-DMA window access with any other mask makes no controller access and is acknowledged with `cpu_rdata` zero.
- R8: No data byte (`ctl_pdma` high) is transferred unless `ctl_drq` was high in the preceding cycle. The access stays open, with no acknowledge, for as long as `ctl_drq` stays low and the timeout has not run out.
- R9: If `ctl_drq` stays low for `tmo_cycles` consecutive cycles while a byte is waiting, the access ends with a one-cycle `cpu_berr`, no acknowledge, and no further bytes. The count restarts for every byte. If `ctl_drq` rises in the cycle in which the count reaches its limit, the byte proceeds.
- R10: Each access ends with exactly one single-cycle pulse on either `cpu_ack` or `cpu_berr`. A `cpu_req` raised while an access is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | One-cycle access request, taken only when idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_win | input | 1 | 1 = pseudo-DMA window, 0 = register window |
| cpu_hoff | input | 12 | Halfword offset within the register window |
| cpu_be | input | 4 | Byte-enable mask, bit 3 = bits [31:24] |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| cpu_ack | output | 1 | One-cycle access completion |
| cpu_berr | output | 1 | One-cycle bus error on timeout |
| tmo_cycles | input | 16 | Per-byte data-request timeout in cycles, at least 1 |
| ctl_sel | output | 1 | One-cycle controller byte strobe |
| ctl_we | output | 1 | Controller write when high |
| ctl_reg | output | 4 | Controller register number |
| ctl_pdma | output | 1 | Strobe is a flow-controlled data byte |
| ctl_wdata | output | 8 | Byte to the controller |
| ctl_rdata | input | 8 | Byte from the controller, sampled at the strobe's closing edge |
| ctl_drq | input | 1 | Controller data request |

## Verification
The per-byte timeout and the data request can land in the same cycle. This happens when `ctl_drq` rises exactly as the wait counter reaches `tmo_cycles - 1`. The bench provokes this by holding the request low for a programmed gap after every strobe. A gap of `tmo_cycles - 1` must let each byte through and end in an acknowledge, even across a burst whose total stall exceeds the limit. A gap of `tmo_cycles` must end in a bus error with no byte moved. A second case holds the data request low while a second request is pulsed. That case checks that the burst completes with only its own bytes once the data request returns.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2,
    ST_DONE = 2'd3
  } seq_state_t;
endpackage

// File: rtl/pdma_lane_count.sv
// Decodes the byte-enable mask into a burst length: only contiguous runs
// that start at the most significant lane and have a power-of-two length.
module pdma_lane_count #(
  parameter int LANES = 4,
  localparam int CW = $clog2(LANES)
) (
  input  logic [LANES-1:0] be,
  output logic [CW-1:0]    last_idx,
  output logic             valid
);
  always_comb begin
    last_idx = '0;
    valid    = 1'b0;
    for (int j = 0; (1 << j) <= LANES; j++) begin
      if (be == LANES'((1 << LANES) - (1 << (LANES - (1 << j))))) begin
        valid    = 1'b1;
        last_idx = CW'((1 << j) - 1);
      end
    end
  end
endmodule

// File: rtl/pdma_wait_timer.sv
// Counts consecutive stalled cycles of one byte; restarts when cleared.
module pdma_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == limit - 1'b1);

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));
endmodule

// File: rtl/pdma_read_lanes.sv
// Read assembly register: one byte register per lane, lane 0 = MSB.
module pdma_read_lanes #(
  parameter int LANES = 4,
  parameter int BW    = 8,
  localparam int CW = $clog2(LANES),
  localparam int DW = LANES * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cap,
  input  logic [CW-1:0] lane,
  input  logic [BW-1:0] din,
  output logic [DW-1:0] word
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [BW-1:0] byte_q;
    logic          load;
    assign load = cap && (lane == CW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     byte_q <= '0;
      else if (clr)   byte_q <= '0;
      else if (load)  byte_q <= din;
    end
    assign word[(LANES-1-k)*BW +: BW] = byte_q;
  end
endmodule

// File: rtl/scsi_pdma_seq.sv
module scsi_pdma_seq
  import pdma_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int BW      = 8,
  parameter int OFFW    = 12,
  parameter int TMO_W   = 16,
  parameter int RIDX_W  = 4,
  parameter int RD_REG  = 6,
  parameter int WR_REG  = 0,
  parameter int RD_OFF  = 'h130,
  parameter int WR_OFF  = 'h100,
  localparam int DW = LANES * BW,
  localparam int CW = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_win,
  input  logic [OFFW-1:0]   cpu_hoff,
  input  logic [LANES-1:0]  cpu_be,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic              cpu_ack,
  output logic              cpu_berr,
  input  logic [TMO_W-1:0]  tmo_cycles,
  output logic              ctl_sel,
  output logic              ctl_we,
  output logic [RIDX_W-1:0] ctl_reg,
  output logic              ctl_pdma,
  output logic [BW-1:0]     ctl_wdata,
  input  logic [BW-1:0]     ctl_rdata,
  input  logic              ctl_drq
);
  localparam int REG_LANE = LANES - 2;

  seq_state_t        st_q, st_d;
  logic [CW-1:0]     idx_q, idx_d, last_q, last_d;
  logic              we_q, we_d, pdma_q, pdma_d, regm_q, regm_d, err_q, err_d;
  logic [RIDX_W-1:0] reg_q, reg_d;
  logic [DW-1:0]     wd_q;

  logic              accept, be_ok, expired, hit_rd, hit_wr;
  logic [CW-1:0]     be_last, rd_lane;
  logic [BW-1:0]     wbyte;

  assign accept = (st_q == ST_IDLE) && cpu_req;
  assign hit_rd = !cpu_we && (cpu_hoff == OFFW'(RD_OFF));
  assign hit_wr =  cpu_we && (cpu_hoff == OFFW'(WR_OFF));

  pdma_lane_count #(.LANES(LANES)) u_cnt (
    .be       (cpu_be),
    .last_idx (be_last),
    .valid    (be_ok)
  );

  pdma_wait_timer #(.TW(TMO_W)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (st_q != ST_WAIT),
    .run     ((st_q == ST_WAIT) && !ctl_drq),
    .limit   (tmo_cycles),
    .expired (expired)
  );

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    last_d = last_q;
    we_d   = we_q;
    pdma_d = pdma_q;
    regm_d = regm_q;
    reg_d  = reg_q;
    err_d  = err_q;
    unique case (st_q)
      ST_IDLE: begin
        if (cpu_req) begin
          we_d  = cpu_we;
          idx_d = '0;
          err_d = 1'b0;
          if (cpu_win) begin
            regm_d = 1'b0;
            pdma_d = 1'b1;
            reg_d  = cpu_we ? RIDX_W'(WR_REG) : RIDX_W'(RD_REG);
            last_d = be_last;
            st_d   = be_ok ? ST_WAIT : ST_DONE;
          end else begin
            regm_d = 1'b1;
            pdma_d = hit_rd || hit_wr;
            reg_d  = cpu_hoff[3 +: RIDX_W];
            last_d = '0;
            st_d   = (hit_rd || hit_wr) ? ST_WAIT : ST_XFER;
          end
        end
      end
      ST_WAIT: begin
        if (ctl_drq) begin
          st_d = ST_XFER;
        end else if (expired) begin
          err_d = 1'b1;
          st_d  = ST_DONE;
        end
      end
      ST_XFER: begin
        if (idx_q == last_q) begin
          st_d = ST_DONE;
        end else begin
          idx_d = idx_q + 1'b1;
          st_d  = ST_WAIT;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      last_q <= '0;
      we_q   <= 1'b0;
      pdma_q <= 1'b0;
      regm_q <= 1'b0;
      reg_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      last_q <= last_d;
      we_q   <= we_d;
      pdma_q <= pdma_d;
      regm_q <= regm_d;
      reg_q  <= reg_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wd_q <= '0;
    else if (accept) wd_q <= cpu_wdata;
  end

  // Write byte: register mode uses bits [15:8], bursts walk down from MSB
  always_comb begin
    wbyte = wd_q[BW +: BW];
    if (!regm_q) begin
      for (int k = 0; k < LANES; k++) begin
        if (idx_q == CW'(k)) wbyte = wd_q[(LANES-1-k)*BW +: BW];
      end
    end
  end

  assign rd_lane = regm_q ? CW'(REG_LANE) : idx_q;

  pdma_read_lanes #(.LANES(LANES), .BW(BW)) u_lanes (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .cap   ((st_q == ST_XFER) && !we_q),
    .lane  (rd_lane),
    .din   (ctl_rdata),
    .word  (cpu_rdata)
  );

  assign ctl_sel   = (st_q == ST_XFER);
  assign ctl_we    = we_q;
  assign ctl_reg   = reg_q;
  assign ctl_pdma  = pdma_q;
  assign ctl_wdata = wbyte;
  assign cpu_ack   = (st_q == ST_DONE) && !err_q;
  assign cpu_berr  = (st_q == ST_DONE) &&  err_q;

  // R8
  drq_before_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_sel && ctl_pdma) |-> $past(ctl_drq));

  // R9
  berr_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_berr |-> $past(!ctl_drq));

  // R10
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);

  // R10
  berr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_berr |=> !cpu_berr);

  // R4, R5, R6
  data_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_sel && ctl_pdma) |-> (ctl_reg == (ctl_we ? RIDX_W'(WR_REG) : RIDX_W'(RD_REG))));
endmodule

// File: tb/sim_scsi_pdma_seq.sv
module sim_scsi_pdma_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we, cpu_win;
  logic [11:0] cpu_hoff;
  logic [3:0]  cpu_be;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        cpu_ack, cpu_berr;
  logic [15:0] tmo_cycles;
  logic        ctl_sel, ctl_we, ctl_pdma, ctl_drq;
  logic [3:0]  ctl_reg;
  logic [7:0]  ctl_wdata, ctl_rdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  scsi_pdma_seq u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_win(cpu_win),
    .cpu_hoff(cpu_hoff), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ack(cpu_ack), .cpu_berr(cpu_berr), .tmo_cycles(tmo_cycles),
    .ctl_sel(ctl_sel), .ctl_we(ctl_we), .ctl_reg(ctl_reg), .ctl_pdma(ctl_pdma),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .ctl_drq(ctl_drq)
  );

  // Controller model: logs every strobe, serves reads A0, A1, ...
  logic       clr;
  logic       drq_en;
  int         budget, gap, gap_cnt, log_n, rd_seq;
  logic [7:0] log_data [8];
  logic [3:0] log_reg  [8];
  logic       log_pdma [8];
  logic       log_we   [8];

  assign ctl_rdata = 8'hA0 + rd_seq[7:0];
  assign ctl_drq   = drq_en && (log_n < budget) && (gap_cnt >= gap);

  always @(posedge clk) begin
    if (clr) begin
      log_n   <= 0;
      rd_seq  <= 0;
      gap_cnt <= 0;
    end else if (ctl_sel) begin
      if (log_n < 8) begin
        log_data[log_n] <= ctl_wdata;
        log_reg[log_n]  <= ctl_reg;
        log_pdma[log_n] <= ctl_pdma;
        log_we[log_n]   <= ctl_we;
      end
      log_n   <= log_n + 1;
      rd_seq  <= rd_seq + (ctl_we ? 0 : 1);
      gap_cnt <= 0;
    end else begin
      gap_cnt <= gap_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_req(input logic win, input logic we, input logic [11:0] hoff,
                           input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    clr = 1'b1; cpu_req = 1'b1; cpu_win = win; cpu_we = we;
    cpu_hoff = hoff; cpu_be = be; cpu_wdata = wd;
    @(negedge clk);
    clr = 1'b0; cpu_req = 1'b0;
  endtask

  task automatic wait_end(output logic got_ack, output logic got_berr, output logic [31:0] rd);
    for (int c = 0; c < 300; c++) begin
      if (cpu_ack || cpu_berr) break;
      @(negedge clk);
    end
    got_ack = cpu_ack; got_berr = cpu_berr; rd = cpu_rdata;
    @(negedge clk);
    chk(!cpu_ack && !cpu_berr, "R10 pulse width", {30'd0, cpu_ack, cpu_berr}, 32'd0);
  endtask

  typedef struct packed {
    logic [3:0]  req;
    logic        win;
    logic        we;
    logic [11:0] hoff;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp_rd;
    logic [2:0]  exp_n;
    logic [3:0]  exp_reg;
    logic        exp_pdma;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 1'b0, 1'b0, 12'h0A8, 4'hF, 32'h0000_0000, 32'h0000_A000, 3'd1, 4'd5, 1'b0}, // R2
    '{4'd3, 1'b0, 1'b1, 12'h018, 4'hF, 32'h1234_5678, 32'h0000_0000, 3'd1, 4'd3, 1'b0}, // R3
    '{4'd4, 1'b0, 1'b0, 12'h130, 4'h0, 32'h0000_0000, 32'h0000_A000, 3'd1, 4'd6, 1'b1}, // R4
    '{4'd4, 1'b0, 1'b1, 12'h100, 4'h0, 32'h0000_C300, 32'h0000_0000, 3'd1, 4'd0, 1'b1}, // R4
    '{4'd4, 1'b0, 1'b0, 12'h100, 4'h0, 32'h0000_0000, 32'h0000_A000, 3'd1, 4'd0, 1'b0}, // R4
    '{4'd4, 1'b0, 1'b1, 12'h130, 4'h0, 32'h0000_7700, 32'h0000_0000, 3'd1, 4'd6, 1'b0}, // R4
    '{4'd5, 1'b1, 1'b0, 12'h000, 4'h8, 32'h0000_0000, 32'hA000_0000, 3'd1, 4'd6, 1'b1}, // R5
    '{4'd5, 1'b1, 1'b0, 12'h000, 4'hC, 32'h0000_0000, 32'hA0A1_0000, 3'd2, 4'd6, 1'b1}, // R5
    '{4'd5, 1'b1, 1'b0, 12'h000, 4'hF, 32'h0000_0000, 32'hA0A1_A2A3, 3'd4, 4'd6, 1'b1}, // R5
    '{4'd6, 1'b1, 1'b1, 12'h000, 4'h8, 32'hDEAD_BEEF, 32'h0000_0000, 3'd1, 4'd0, 1'b1}, // R6
    '{4'd6, 1'b1, 1'b1, 12'h000, 4'hC, 32'hDEAD_BEEF, 32'h0000_0000, 3'd2, 4'd0, 1'b1}, // R6
    '{4'd6, 1'b1, 1'b1, 12'h000, 4'hF, 32'hDEAD_BEEF, 32'h0000_0000, 3'd4, 4'd0, 1'b1}, // R6
    '{4'd7, 1'b1, 1'b0, 12'h000, 4'h6, 32'h0000_0000, 32'h0000_0000, 3'd0, 4'd0, 1'b0}, // R7
    '{4'd7, 1'b1, 1'b1, 12'h000, 4'h3, 32'hFFFF_FFFF, 32'h0000_0000, 3'd0, 4'd0, 1'b0}  // R7
  };

  // Watchdog
  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic        a, b;
    logic [31:0] rd;
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_win = 1'b0; cpu_hoff = '0;
    cpu_be = '0; cpu_wdata = '0; tmo_cycles = 16'd50; clr = 1'b1;
    drq_en = 1'b1; budget = 99; gap = 0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!cpu_ack && !cpu_berr && !ctl_sel && cpu_rdata == 0, "R1 in reset", cpu_rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_ack && !cpu_berr && !ctl_sel && cpu_rdata == 0, "R1 after reset", cpu_rdata, 32'd0);
    clr = 1'b0;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d vec%0d", v.req, i);
      start_req(v.win, v.we, v.hoff, v.be, v.wd);
      wait_end(a, b, rd);
      chk(a && !b, {tag, " ack"}, {30'd0, a, b}, 32'd2);
      if (!v.we) chk(rd == v.exp_rd, {tag, " rdata"}, rd, v.exp_rd);
      chk(log_n == int'(v.exp_n), {tag, " byte count"}, log_n, 32'(v.exp_n));
      for (int k = 0; k < int'(v.exp_n); k++) begin
        logic [7:0] eb;
        eb = v.win ? v.wd[31-8*k -: 8] : v.wd[15:8];
        chk(log_reg[k] == v.exp_reg && log_pdma[k] == v.exp_pdma && log_we[k] == v.we,
            {tag, " reg/pdma/dir"}, {23'd0, log_we[k], log_pdma[k], 3'd0, log_reg[k]},
            {23'd0, v.we, v.exp_pdma, 3'd0, v.exp_reg});
        if (v.we) chk(log_data[k] == eb, {tag, " write byte"}, 32'(log_data[k]), 32'(eb));
      end
    end

    // R8 stall and R10 ignored request during busy
    tmo_cycles = 16'd50;
    drq_en = 1'b0;
    start_req(1'b1, 1'b1, 12'h000, 4'hF, 32'h0102_0304);
    repeat (6) @(negedge clk);
    chk(log_n == 0 && !cpu_ack && !cpu_berr, "R8 stalled without drq", log_n, 32'd0);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_win = 1'b0; cpu_hoff = 12'h0A8;
    @(negedge clk);
    cpu_req = 1'b0;
    repeat (3) @(negedge clk);
    drq_en = 1'b1;
    wait_end(a, b, rd);
    chk(a && !b, "R8 ack after drq", {30'd0, a, b}, 32'd2);
    chk(log_n == 4 && log_we[0] && log_reg[0] == 0 && log_data[3] == 8'h04,
        "R10 busy request ignored", log_n, 32'd4);
    repeat (4) @(negedge clk);
    chk(log_n == 4 && !cpu_ack, "R10 no second access", log_n, 32'd4);

    // R9 timeout on first byte
    tmo_cycles = 16'd8;
    drq_en = 1'b0;
    start_req(1'b1, 1'b0, 12'h000, 4'h8, 32'h0);
    wait_end(a, b, rd);
    chk(b && !a && log_n == 0, "R9 timeout berr", {30'd0, a, b}, 32'd1);
    drq_en = 1'b1;

    // R9 timeout mid-burst: only two bytes moved
    budget = 2;
    start_req(1'b1, 1'b1, 12'h000, 4'hF, 32'hCAFE_F00D);
    wait_end(a, b, rd);
    chk(b && !a, "R9 mid-burst berr", {30'd0, a, b}, 32'd1);
    chk(log_n == 2, "R9 no bytes after berr", log_n, 32'd2);
    budget = 99;

    // R9 drq arrives in the cycle the count reaches its limit; restarts per byte
    tmo_cycles = 16'd4;
    gap = 3;
    start_req(1'b1, 1'b0, 12'h000, 4'hC, 32'h0);
    wait_end(a, b, rd);
    chk(a && !b, "R9 drq wins at limit", {30'd0, a, b}, 32'd2);
    chk(rd == 32'hA0A1_0000 && log_n == 2, "R9 restart per byte", rd, 32'hA0A1_0000);

    // R9 drq one cycle late: timeout
    gap = 4;
    start_req(1'b1, 1'b0, 12'h000, 4'h8, 32'h0);
    wait_end(a, b, rd);
    chk(b && !a && log_n == 0, "R9 drq late", {30'd0, a, b}, 32'd1);
    gap = 0;

    // R2 after errors, ordinary access still fine
    start_req(1'b0, 1'b0, 12'h078, 4'h0, 32'h0);
    wait_end(a, b, rd);
    chk(a && rd == 32'h0000_A000 && log_reg[0] == 4'hF && !log_pdma[0],
        "R2 reg 15 read", rd, 32'h0000_A000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule